// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers up to 64 interrupt request lines and offers the processor one interrupt output and a vector register. The vector register names the most urgent source that is both pending and enabled. Software programs the block through a simple synchronous register bus. The bus has a word address, a write strobe, 32-bit write data and combinational read data.

Each source has its own setup register. That register chooses level or edge sensing and gives the source a priority level. Enables are changed through separate set and clear registers, so software never needs a read-modify-write. A write to the acknowledge register retires the current interrupt. A software reset clears all programmable state, and a global generation switch gates the output pin. A small table records a register-set number for each source, so that a handler can pick a shadow register set.

To clear a latched edge, software writes the source's setup register with the edge bit low, then writes the original value back. When nothing qualifies, the vector register reads 64, and software treats that value as spurious.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A write to ENA word w (byte address 0x000 + 4*w; w=0 covers sources 0..31, w=1 covers 32..63) sets the enable of every source whose data bit is 1 and leaves the others unchanged. Reading that address returns the enable word.
- R2: A write to DIS word w (byte address 0x040 + 4*w) clears the enable of every source whose data bit is 1 and leaves the others unchanged.
- R3: Source n has a setup register at byte address 0x200 + 8*n. Bit 8 of that register selects edge sensing (1) or level sensing (0), and bits 3:0 hold the priority level. Reading the register returns the written value restricted to those bits.
- R4: A level source is pending while its request line is high, one clock after the line is sampled. It stops being pending once the line is low. Pending state reads at byte address 0x0C0 + 4*w.
- R5: An edge source latches a rising edge of its request line and stays pending after the line falls. A setup write with bit 8 at 0 clears the latch.
- R6: The vector register (byte address 0x080) reports the enabled pending source with the highest priority level. A tie goes to the lowest source number. The register is updated one clock after the pending state changes.
- R7: When no enabled source is pending, the vector register reads 64.
- R12: A disabled source is never selected, even when it is pending at a higher priority level.
- R8: irq_o stays low while bit 0 of the generation register (byte address 0x08C, readable) is 0. While that bit is 1, irq_o is high whenever a source is selected.
- R9: Any write to the acknowledge register (byte address 0x084) forces irq_o low for the following cycle. After that, irq_o is evaluated again.
- R10: A reset leaves every enable, setup, generation and table entry at 0, with irq_o low and the vector register at 64. The reset may be the rst_n input or a write with bit 0 set to the reset register (byte address 0x088).
- R11: A write to the binding register (byte address 0x090) stores data bits 3:0 as the register-set number of the source given in data bits 21:16. Entry n reads back at byte address 0x600 + 4*n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 64 | Interrupt request lines, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A table of request and enable patterns drives the selector. The patterns cover a priority tie between two sources, which shows that the lowest number wins. A higher-priority source in the upper word shows that priority beats source number. The same pattern with that source masked shows that the enable is honoured. A low-priority source against a priority-0 source shows that the comparison uses the level and not the position. The patterns with no request, and with requests but no enables, tell the spurious code apart from source 0. Directed sequences then compare a held request against a single pulse, once in level mode and once in edge mode. These sequences also follow the edge-clear write pair, the acknowledge gap, the generation gate, the binding table and the software reset.

// File: rtl/prio_irq_pkg.sv
// Shared constants of the interrupt controller: register byte offsets,
// field positions and the bus word width. Offsets are 32 bits wide and
// compared against a zero-extended bus address.
package prio_irq_pkg;
    localparam int          WORD_W       = 32;
    localparam logic [31:0] OFS_ENA      = 32'h000;
    localparam logic [31:0] OFS_DIS      = 32'h040;
    localparam logic [31:0] OFS_VEC      = 32'h080;
    localparam logic [31:0] OFS_ACK      = 32'h084;
    localparam logic [31:0] OFS_RST      = 32'h088;
    localparam logic [31:0] OFS_GEN      = 32'h08C;
    localparam logic [31:0] OFS_BIND     = 32'h090;
    localparam logic [31:0] OFS_PEND     = 32'h0C0;
    localparam logic [31:0] OFS_SETUP    = 32'h200;
    localparam logic [31:0] OFS_BIND_RD  = 32'h600;
    localparam int          EDGE_BIT     = 8;
    localparam int          BIND_SRC_LSB = 16;
endpackage

// File: rtl/prio_irq_regs.sv
// Programmable state of the controller: the enable words, the per-source
// setup registers, the generation switch and the register-set table.
// It also decodes the strobes for acknowledge, software reset and
// edge-latch clear. Assumes NSRC is a multiple of the 32-bit word.
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 4,
    parameter int SET_W  = 4,
    parameter int ADDR_W = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [WORD_W-1:0]                 bus_wdata,
    output logic [NSRC-1:0]                   ena,
    output logic [NSRC-1:0]                   edge_sel,
    output logic [NSRC-1:0][PRIO_W-1:0]       prio,
    output logic [NSRC-1:0][SET_W-1:0]        bind_tbl,
    output logic                              gen_en,
    output logic                              soft_rst,
    output logic                              ack_wr,
    output logic [NSRC-1:0]                   edge_clr,
    output logic                              setup_hit,
    output logic [$clog2(NSRC)-1:0]           setup_idx
);
    localparam int NWORD = NSRC / WORD_W;
    localparam int IDX_W = $clog2(NSRC);

    logic [31:0]       a32;
    logic [31:0]       setup_off;
    logic [IDX_W-1:0]  bind_src;

    // Address decode of the strobes and of the setup window.
    always_comb begin
        a32       = 32'(bus_addr);
        setup_off = a32 - OFS_SETUP;
        setup_hit = (a32 >= OFS_SETUP) && (a32 < OFS_SETUP + 32'(NSRC * 8))
                    && (a32[2:0] == 3'b000);
        setup_idx = setup_off[IDX_W+2:3];
        soft_rst  = bus_we && (a32 == OFS_RST) && bus_wdata[0];
        ack_wr    = bus_we && (a32 == OFS_ACK);
        bind_src  = bus_wdata[BIND_SRC_LSB +: IDX_W];
    end

    // Edge-clear strobe: a setup write with the edge bit low.
    always_comb begin
        edge_clr = '0;
        for (int i = 0; i < NSRC; i++) begin
            edge_clr[i] = bus_we && setup_hit && (setup_idx == IDX_W'(i))
                          && !bus_wdata[EDGE_BIT];
        end
    end

    // One set/clear enable word per group of 32 sources.
    for (genvar w = 0; w < NWORD; w++) begin : g_word
        logic [WORD_W-1:0] ena_q;

        // Set bits through ENA, clear bits through DIS.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                ena_q <= '0;
            end else if (bus_we && a32 == OFS_ENA + 32'(w * 4)) begin
                ena_q <= ena_q | bus_wdata;
            end else if (bus_we && a32 == OFS_DIS + 32'(w * 4)) begin
                ena_q <= ena_q & ~bus_wdata;
            end
        end

        assign ena[w*WORD_W +: WORD_W] = ena_q;
    end

    // Setup registers: edge select and priority level per source.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            edge_sel <= '0;
            prio     <= '0;
        end else if (bus_we && setup_hit) begin
            edge_sel[setup_idx] <= bus_wdata[EDGE_BIT];
            prio[setup_idx]     <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Global generation switch.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            gen_en <= 1'b0;
        end else if (bus_we && a32 == OFS_GEN) begin
            gen_en <= bus_wdata[0];
        end
    end

    // Register-set binding table, one entry per source.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            bind_tbl <= '0;
        end else if (bus_we && a32 == OFS_BIND) begin
            bind_tbl[bind_src] <= bus_wdata[SET_W-1:0];
        end
    end
endmodule

// File: rtl/prio_irq_pend.sv
// Request sampling and pending state. Each request line is registered
// once. A level source is pending while the sampled line is high. An
// edge source latches a rising edge until its clear strobe arrives,
// and the clear wins over a new edge in the same cycle.
// Assumes the request lines are synchronous to clk.
module prio_irq_pend #(
    parameter int NSRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] edge_sel,
    input  logic [NSRC-1:0] edge_clr,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] req_q;
    logic [NSRC-1:0] latch_q;
    logic [NSRC-1:0] rise;

    assign rise = irq_req & ~req_q & edge_sel;

    // Sample the request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= irq_req;
        end
    end

    // Hold captured edges until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            latch_q <= '0;
        end else begin
            latch_q <= (latch_q | rise) & ~edge_clr;
        end
    end

    // Per source, choose the latched or the live pending state.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            pend[i] = edge_sel[i] ? latch_q[i] : req_q[i];
        end
    end
endmodule

// File: rtl/prio_irq_arb.sv
// Combinational selector. It picks the candidate with the highest
// priority level, and the lowest index wins a tie. Found is low when
// there is no candidate. The scan is linear over NSRC.
module prio_irq_arb #(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 4
) (
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                        found,
    output logic [$clog2(NSRC)-1:0]     sel
);
    localparam int IDX_W = $clog2(NSRC);

    logic [PRIO_W-1:0] best;

    // A strictly greater level displaces the current winner.
    always_comb begin
        found = 1'b0;
        best  = '0;
        sel   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!found || prio[i] > best)) begin
                found = 1'b1;
                best  = prio[i];
                sel   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the interrupt controller. It joins the register file, the
// pending logic and the selector. It registers the vector and the
// interrupt output, and it drives the combinational read mux.
// Assumes a single clock and synchronous request lines.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 4,
    parameter int SET_W  = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int IDX_W = $clog2(NSRC);
    localparam int NWORD = NSRC / WORD_W;

    logic [NSRC-1:0]             ena;
    logic [NSRC-1:0]             edge_sel;
    logic [NSRC-1:0][PRIO_W-1:0] prio;
    logic [NSRC-1:0][SET_W-1:0]  bind_tbl;
    logic                        gen_en;
    logic                        soft_rst;
    logic                        ack_wr;
    logic [NSRC-1:0]             edge_clr;
    logic                        setup_hit;
    logic [IDX_W-1:0]            setup_idx;
    logic [NSRC-1:0]             pend;
    logic                        found;
    logic [IDX_W-1:0]            sel;
    logic [IDX_W:0]              vec_q;
    logic                        irq_q;
    logic [31:0]                 a32;
    logic [31:0]                 bind_off;
    logic [IDX_W-1:0]            bind_idx;

    prio_irq_regs #(
        .NSRC(NSRC), .PRIO_W(PRIO_W), .SET_W(SET_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ena(ena), .edge_sel(edge_sel), .prio(prio),
        .bind_tbl(bind_tbl), .gen_en(gen_en), .soft_rst(soft_rst),
        .ack_wr(ack_wr), .edge_clr(edge_clr), .setup_hit(setup_hit),
        .setup_idx(setup_idx)
    );

    prio_irq_pend #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_req(irq_req),
        .edge_sel(edge_sel), .edge_clr(edge_clr), .pend(pend)
    );

    prio_irq_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .cand(pend & ena), .prio(prio), .found(found), .sel(sel)
    );

    // Register the vector; NSRC stands for "nothing selected".
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            vec_q <= (IDX_W+1)'(NSRC);
        end else begin
            vec_q <= found ? {1'b0, sel} : (IDX_W+1)'(NSRC);
        end
    end

    // Output request: gated by generation, cleared for a cycle by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= gen_en && found && !ack_wr;
        end
    end

    assign irq_o = irq_q;

    // Read-back address decode for the binding table.
    always_comb begin
        a32      = 32'(bus_addr);
        bind_off = a32 - OFS_BIND_RD;
        bind_idx = bind_off[IDX_W+1:2];
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (a32 == OFS_ENA + 32'(w * 4)) bus_rdata = ena[w*WORD_W +: WORD_W];
            if (a32 == OFS_PEND + 32'(w * 4)) bus_rdata = pend[w*WORD_W +: WORD_W];
        end
        if (a32 == OFS_VEC) bus_rdata = 32'(vec_q);
        if (a32 == OFS_GEN) bus_rdata = {31'b0, gen_en};
        if (setup_hit) begin
            bus_rdata[EDGE_BIT]     = edge_sel[setup_idx];
            bus_rdata[PRIO_W-1:0]   = prio[setup_idx];
        end
        if (a32 >= OFS_BIND_RD && a32 < OFS_BIND_RD + 32'(NSRC * 4)
            && a32[1:0] == 2'b00) begin
            bus_rdata = 32'(bind_tbl[bind_idx]);
        end
    end
endmodule

// File: rtl/prio_irq_chk.sv
// Property checker for the interrupt controller. It watches the bus
// strobes, the output, the registered vector, the generation bit and
// the enable word of sources 0..31. It is attached by the bind below.
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int ADDR_W = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [31:0]               bus_wdata,
    input logic                      irq_o,
    input logic [$clog2(NSRC):0]     vec,
    input logic                      gen_en,
    input logic [NSRC-1:0]           ena
);
    logic [31:0] a32;
    assign a32 = 32'(bus_addr);

    // R1: set bits become 1, zero bits keep their value
    p_set_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a32 == OFS_ENA) |=>
        ((ena[31:0] & $past(bus_wdata)) == $past(bus_wdata)) &&
        ((ena[31:0] & ~$past(bus_wdata)) == ($past(ena[31:0]) & ~$past(bus_wdata))));

    // R2: clear bits become 0
    p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a32 == OFS_DIS) |=> ((ena[31:0] & $past(bus_wdata)) == 32'h0));

    // R6: an asserted output always has a valid vector behind it
    p_irq_has_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec < ($clog2(NSRC)+1)'(NSRC)));

    // R7: the vector never exceeds the spurious code
    p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec <= ($clog2(NSRC)+1)'(NSRC));

    // R8: generation off keeps the output low
    p_gen_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !irq_o);

    // R9: acknowledge drops the output for a cycle
    p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a32 == OFS_ACK) |=> !irq_o);

    // R10: software reset clears enables, generation and output
    p_soft_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a32 == OFS_RST && bus_wdata[0]) |=>
        (ena == '0) && !gen_en && !irq_o && (vec == ($clog2(NSRC)+1)'(NSRC)));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_o(irq_o), .vec(vec_q), .gen_en(gen_en),
    .ena(ena)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic [63:0] req;
        logic [63:0] ena;
        logic [6:0]  exp;
    } vec_t;

    // Sources 5 and 9 have level 3, source 40 has level 7, source 63 has level 1; all others level 0.
    localparam vec_t TBL [8] = '{
        '{64'h0000_0000_0000_0220, 64'hFFFF_FFFF_FFFF_FFFF, 7'd5},
        '{64'h0000_0100_0000_0220, 64'hFFFF_FFFF_FFFF_FFFF, 7'd40},
        '{64'h0000_0100_0000_0220, 64'hFFFF_FEFF_FFFF_FFFF, 7'd5},
        '{64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 7'd63},
        '{64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 7'd0},
        '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 7'd64},
        '{64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 7'd64},
        '{64'h0000_0002_0000_0004, 64'hFFFF_FFFF_FFFF_FFFF, 7'd2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_ena(input logic [63:0] e);
        bus_wr(12'h040, 32'hFFFF_FFFF);
        bus_wr(12'h044, 32'hFFFF_FFFF);
        bus_wr(12'h000, e[31:0]);
        bus_wr(12'h004, e[63:32]);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;

        // R10: state after the reset input
        bus_rd(12'h000, rd); check("R10 ena after reset", rd, 32'h0);
        bus_rd(12'h080, rd); check("R10 vector after reset", rd, 32'd64);
        bus_rd(12'h08C, rd); check("R10 gen after reset", rd, 32'h0);
        check("R10 irq after reset", {31'b0, irq_o}, 32'h0);

        // R1 / R2: set and clear enable words
        bus_wr(12'h000, 32'h0000_00F0);
        bus_rd(12'h000, rd); check("R1 set low word", rd, 32'h0000_00F0);
        bus_wr(12'h000, 32'h0000_0003);
        bus_rd(12'h000, rd); check("R1 zero bits kept", rd, 32'h0000_00F3);
        bus_wr(12'h040, 32'h0000_0030);
        bus_rd(12'h000, rd); check("R2 clear low word", rd, 32'h0000_00C3);
        bus_wr(12'h004, 32'h8000_0001);
        bus_rd(12'h004, rd); check("R1 set high word", rd, 32'h8000_0001);
        bus_wr(12'h044, 32'h8000_0000);
        bus_rd(12'h004, rd); check("R2 clear high word", rd, 32'h0000_0001);

        // R3: setup register stride and field masking
        bus_wr(12'h238, 32'hFFFF_F105);
        bus_rd(12'h238, rd); check("R3 setup 7 readback", rd, 32'h0000_0105);
        bus_rd(12'h230, rd); check("R3 setup 6 untouched", rd, 32'h0);
        bus_wr(12'h238, 32'h0);

        // Priorities used by the table
        bus_wr(12'h228, 32'h3);
        bus_wr(12'h248, 32'h3);
        bus_wr(12'h340, 32'h7);
        bus_wr(12'h3F8, 32'h1);
        bus_wr(12'h08C, 32'h1);

        // R6 / R7 / R12: selector patterns
        for (int k = 0; k < 8; k++) begin
            set_ena(TBL[k].ena);
            @(negedge clk);
            irq_req = TBL[k].req;
            wait_cyc(3);
            bus_rd(12'h080, rd);
            check($sformatf("R6 R7 R12 vector pattern %0d", k), rd, 32'(TBL[k].exp));
            check($sformatf("R8 irq pattern %0d", k), {31'b0, irq_o},
                  {31'b0, (TBL[k].exp < 7'd64)});
            @(negedge clk);
            irq_req = '0;
            wait_cyc(3);
        end

        // R4: a level source follows its line
        set_ena(64'h20);
        @(negedge clk); irq_req[5] = 1'b1;
        wait_cyc(3);
        bus_rd(12'h080, rd); check("R4 level held", rd, 32'd5);
        bus_rd(12'h0C0, rd); check("R4 pending bit", rd, 32'h20);
        @(negedge clk); irq_req[5] = 1'b0;
        wait_cyc(3);
        bus_rd(12'h080, rd); check("R4 level released", rd, 32'd64);

        // R5: an edge source latches a pulse; the write pair clears it
        set_ena(64'h1000);
        bus_wr(12'h260, 32'h102);
        @(negedge clk); irq_req[12] = 1'b1;
        @(negedge clk); irq_req[12] = 1'b0;
        wait_cyc(3);
        bus_rd(12'h080, rd); check("R5 edge latched", rd, 32'd12);
        bus_rd(12'h0C0, rd); check("R5 pending latched", rd, 32'h1000);
        bus_wr(12'h260, 32'h002);
        bus_wr(12'h260, 32'h102);
        bus_rd(12'h0C0, rd); check("R5 latch cleared", rd, 32'h0);
        wait_cyc(2);
        bus_rd(12'h080, rd); check("R5 vector after clear", rd, 32'd64);

        // R9: acknowledge gap
        set_ena(64'h20);
        @(negedge clk); irq_req[5] = 1'b1;
        wait_cyc(3);
        check("R9 irq before ack", {31'b0, irq_o}, 32'h1);
        bus_wr(12'h084, 32'h0);
        check("R9 irq after ack", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq re-evaluated", {31'b0, irq_o}, 32'h1);

        // R8: the generation switch gates the output only
        bus_wr(12'h08C, 32'h0);
        wait_cyc(2);
        check("R8 irq gated", {31'b0, irq_o}, 32'h0);
        bus_rd(12'h080, rd); check("R8 vector while gated", rd, 32'd5);
        bus_wr(12'h08C, 32'h1);
        wait_cyc(2);
        check("R8 irq ungated", {31'b0, irq_o}, 32'h1);

        // R11: binding table
        bus_wr(12'h090, (32'd17 << 16) | 32'd9);
        bus_rd(12'h644, rd); check("R11 entry 17", rd, 32'd9);
        bus_rd(12'h648, rd); check("R11 entry 18", rd, 32'd0);

        // R10: software reset
        bus_wr(12'h260, 32'h105);
        bus_wr(12'h088, 32'h1);
        check("R10 irq after soft reset", {31'b0, irq_o}, 32'h0);
        bus_rd(12'h000, rd); check("R10 ena after soft reset", rd, 32'h0);
        bus_rd(12'h08C, rd); check("R10 gen after soft reset", rd, 32'h0);
        bus_rd(12'h260, rd); check("R10 setup after soft reset", rd, 32'h0);
        bus_rd(12'h644, rd); check("R10 table after soft reset", rd, 32'h0);
        bus_rd(12'h080, rd); check("R10 vector after soft reset", rd, 32'd64);
        irq_req = '0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule